// File: doc/BRIEF.md
# Dual-Lane PHY Attribute Access Bridge

This block gives a host processor register access to the configuration attributes of a serial PHY with two lanes. The host selects an attribute by its identifier, places a value in a staging register when writing, and sets bits in a control register. The block turns each newly set control bit into a one-cycle strobe towards one lane's attribute store. A read strobe copies the lane's active value into that lane's own read-back register. A write strobe places the value in the lane's pending set. A configuration-update strobe makes pending values active.

Each lane keeps a pending and an active copy of every supported attribute. The attribute class (transmitter or receiver) follows from the identifier. An update strobe acts only when its class matches the class of the attribute currently selected. When it acts, it promotes every pending entry of that class. When all lanes read in the same access and return different values, a sticky flag is raised.

Top module: `attr_bridge`

## Requirements
- R1: After reset every host-visible register reads zero, every stored attribute value is zero and `lane_mismatch` is low.
- R2: Register offsets are: control 0x16C, attribute identifier 0x170, staged write value 0x174, lane n read-back 0x178 + 4·n. The control, identifier and write-value registers read back the full word last written. Any other offset reads zero.
- R3: Each lane n owns control bits 4n to 4n+3, in this order: read, write, transmitter update, receiver update. A strobe reaches only the lane whose bit was set.
- R4: A strobe is issued only when a control bit goes from 0 to 1 through a host write. Rewriting a bit that is already 1 has no effect. A new access therefore requires the bit to be cleared first.
- R5: A read strobe loads the lane's read-back register with the active value of the selected attribute, zero-extended above the value width. The register then holds that value until the next read strobe.
- R6: A write strobe changes only the pending copy. Reads keep returning the previous active value until an update.
- R7: An identifier numerically below 0xA1 selects the transmitter class, and any other identifier selects the receiver class. An update strobe whose class differs from the selected identifier's class is ignored. A matching update promotes all pending entries of that class.
- R8: Supported identifiers are 0x21 to 0x34 and 0xA1 to 0xA8, plus 0x89; an identifier with any bit set above bit 7 is unsupported. A write to an unsupported identifier is discarded and leaves every supported attribute unchanged. A read of one returns zero.
- R9: When a write and a matching update reach a lane in the same strobe cycle, the written value becomes active immediately.
- R10: If all lanes read in the same strobe cycle and their read-back values differ, `lane_mismatch` rises one cycle after the read-back registers load. It then stays high until reset.
- R11: Identifier 0x89 falls below the class boundary and is promoted only by a transmitter update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write enable, one cycle per write |
| bus_addr | input | 12 | Host byte offset for write and read |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| lane_mismatch | output | 1 | Sticky flag: lanes returned different values in one read |

## Verification
Two pairs of functions can land in the same strobe cycle. The first pair is a pending write and a configuration update. The bench provokes it with one control write that carries both the write and the update bits, and it requires the freshly written value to be active at the next read. The second pair is the reads of the two lanes, which always share a cycle. The bench makes the lanes disagree by writing and updating lane 0 alone, then requires the mismatch flag to rise and to stay raised through later matching reads.

// File: rtl/attr_bridge_pkg.sv
package attr_bridge_pkg;

   localparam int ID_W = 8;

   localparam logic [ID_W-1:0] TX_LO       = 8'h21;
   localparam logic [ID_W-1:0] TX_HI       = 8'h34;
   localparam logic [ID_W-1:0] RX_LO       = 8'hA1;
   localparam logic [ID_W-1:0] RX_HI       = 8'hA8;
   localparam logic [ID_W-1:0] RX_EXTRA    = 8'h89;
   localparam logic [ID_W-1:0] CLASS_BOUND = 8'hA1;

   localparam int TX_CNT   = int'(TX_HI) - int'(TX_LO) + 1;
   localparam int RX_CNT   = int'(RX_HI) - int'(RX_LO) + 1;
   localparam int NUM_ATTR = TX_CNT + RX_CNT + 1;
   localparam int IDX_W    = $clog2(NUM_ATTR);

   // bit position of each operation inside one lane's control nibble
   typedef enum int {
      OP_RD  = 0,
      OP_WR  = 1,
      OP_TXU = 2,
      OP_RXU = 3
   } lane_op_e;

   localparam int OPS_PER_LANE = 4;

   typedef struct packed {
      logic             hit;
      logic [IDX_W-1:0] idx;
   } slot_t;

   function automatic slot_t locate(input logic [ID_W-1:0] id);
      slot_t s;
      s.hit = 1'b0;
      s.idx = '0;
      if (id >= TX_LO && id <= TX_HI) begin
         s.hit = 1'b1;
         s.idx = IDX_W'(int'(id) - int'(TX_LO));
      end else if (id >= RX_LO && id <= RX_HI) begin
         s.hit = 1'b1;
         s.idx = IDX_W'(TX_CNT + int'(id) - int'(RX_LO));
      end else if (id == RX_EXTRA) begin
         s.hit = 1'b1;
         s.idx = IDX_W'(TX_CNT + RX_CNT);
      end
      return s;
   endfunction

   function automatic logic [ID_W-1:0] slot_id(input int i);
      if (i < TX_CNT)               return ID_W'(int'(TX_LO) + i);
      else if (i < TX_CNT + RX_CNT) return ID_W'(int'(RX_LO) + i - TX_CNT);
      else                          return RX_EXTRA;
   endfunction

   function automatic logic class_is_tx(input logic [ID_W-1:0] id);
      return id < CLASS_BOUND;
   endfunction

endpackage

// File: rtl/attr_bridge_regs.sv
module attr_bridge_regs #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int LANES    = 2,
   parameter int VAL_W    = 8,
   parameter int CTRL_OFS = 'h16C,
   parameter int ID_OFS   = 'h170,
   parameter int WVAL_OFS = 'h174,
   parameter int RDV_OFS  = 'h178
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   input  logic [LANES-1:0][VAL_W-1:0] lane_rdval,
   output logic [DATA_W-1:0]           id_q,
   output logic [DATA_W-1:0]           wval_q,
   output logic [4*LANES-1:0]          strobe_q
);
   localparam int CW = 4 * LANES;

   logic [DATA_W-1:0] ctrl_q;
   logic              sel_ctrl, sel_id, sel_wval;

   assign sel_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
   assign sel_id   = bus_wr && (bus_addr == ADDR_W'(ID_OFS));
   assign sel_wval = bus_wr && (bus_addr == ADDR_W'(WVAL_OFS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         id_q     <= '0;
         wval_q   <= '0;
         strobe_q <= '0;
      end else begin
         if (sel_ctrl) ctrl_q <= bus_wdata;
         if (sel_id)   id_q   <= bus_wdata;
         if (sel_wval) wval_q <= bus_wdata;
         // only bits that go from clear to set produce a pulse
         strobe_q <= sel_ctrl ? (bus_wdata[CW-1:0] & ~ctrl_q[CW-1:0]) : '0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CTRL_OFS)) bus_rdata = ctrl_q;
      if (bus_addr == ADDR_W'(ID_OFS))   bus_rdata = id_q;
      if (bus_addr == ADDR_W'(WVAL_OFS)) bus_rdata = wval_q;
      for (int n = 0; n < LANES; n++) begin
         if (bus_addr == ADDR_W'(RDV_OFS + 4 * n))
            bus_rdata = DATA_W'(lane_rdval[n]);
      end
   end

endmodule

// File: rtl/attr_lane_store.sv
module attr_lane_store
   import attr_bridge_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int VAL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic              txu_stb,
   input  logic              rxu_stb,
   input  logic [DATA_W-1:0] attr_id,
   input  logic [VAL_W-1:0]  wr_val,
   output logic [VAL_W-1:0]  rd_val
);
   logic [VAL_W-1:0] pend [NUM_ATTR];
   logic [VAL_W-1:0] act  [NUM_ATTR];

   slot_t slot;
   logic  id_narrow, hit, sel_tx, upd_tx, upd_rx;

   assign id_narrow = (attr_id[DATA_W-1:ID_W] == '0);
   assign slot      = locate(attr_id[ID_W-1:0]);
   assign hit       = id_narrow && slot.hit;
   assign sel_tx    = id_narrow && class_is_tx(attr_id[ID_W-1:0]);
   assign upd_tx    = txu_stb && sel_tx;
   assign upd_rx    = rxu_stb && !sel_tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ATTR; i++) begin
            pend[i] <= '0;
            act[i]  <= '0;
         end
         rd_val <= '0;
      end else begin
         if (wr_stb && hit) pend[slot.idx] <= wr_val;
         for (int i = 0; i < NUM_ATTR; i++) begin
            if ((upd_tx && class_is_tx(slot_id(i))) ||
                (upd_rx && !class_is_tx(slot_id(i)))) begin
               // a write in the same cycle is forwarded straight to active
               act[i] <= (wr_stb && hit && slot.idx == IDX_W'(i)) ? wr_val : pend[i];
            end
         end
         if (rd_stb) rd_val <= hit ? act[slot.idx] : '0;
      end
   end

endmodule

// File: rtl/attr_bridge_cmp.sv
module attr_bridge_cmp #(
   parameter int LANES = 2,
   parameter int VAL_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LANES-1:0]            rd_stb,
   input  logic [LANES-1:0][VAL_W-1:0] rdval,
   output logic                        mismatch
);
   logic all_read_q;
   logic differ;

   always_comb begin
      differ = 1'b0;
      for (int n = 1; n < LANES; n++)
         if (rdval[n] != rdval[0]) differ = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         all_read_q <= 1'b0;
         mismatch   <= 1'b0;
      end else begin
         all_read_q <= &rd_stb;
         if (all_read_q && differ) mismatch <= 1'b1;
      end
   end

endmodule

// File: rtl/attr_bridge.sv
module attr_bridge
   import attr_bridge_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int LANES    = 2,
   parameter int VAL_W    = 8,
   parameter int CTRL_OFS = 'h16C,
   parameter int ID_OFS   = 'h170,
   parameter int WVAL_OFS = 'h174,
   parameter int RDV_OFS  = 'h178
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              lane_mismatch
);
   localparam int CW = OPS_PER_LANE * LANES;

   if (LANES < 2) begin : g_bad_lanes
      $error("attr_bridge: at least two lanes are needed");
   end
   if (CW > DATA_W || VAL_W > DATA_W || ID_W >= DATA_W) begin : g_bad_width
      $error("attr_bridge: control, value or id width exceeds data width");
   end

   logic [DATA_W-1:0]           id_q, wval_q;
   logic [CW-1:0]               strobe;
   logic [LANES-1:0]            stb_rd;
   logic [LANES-1:0][VAL_W-1:0] lane_rdval;

   attr_bridge_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES), .VAL_W(VAL_W),
      .CTRL_OFS(CTRL_OFS), .ID_OFS(ID_OFS), .WVAL_OFS(WVAL_OFS), .RDV_OFS(RDV_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .lane_rdval(lane_rdval),
      .id_q(id_q), .wval_q(wval_q), .strobe_q(strobe)
   );

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      assign stb_rd[n] = strobe[OPS_PER_LANE*n + OP_RD];
      attr_lane_store #(.DATA_W(DATA_W), .VAL_W(VAL_W)) u_store (
         .clk(clk), .rst_n(rst_n),
         .rd_stb(stb_rd[n]),
         .wr_stb(strobe[OPS_PER_LANE*n + OP_WR]),
         .txu_stb(strobe[OPS_PER_LANE*n + OP_TXU]),
         .rxu_stb(strobe[OPS_PER_LANE*n + OP_RXU]),
         .attr_id(id_q),
         .wr_val(wval_q[VAL_W-1:0]),
         .rd_val(lane_rdval[n])
      );
   end

   attr_bridge_cmp #(.LANES(LANES), .VAL_W(VAL_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .rd_stb(stb_rd), .rdval(lane_rdval), .mismatch(lane_mismatch)
   );

endmodule

// File: rtl/attr_bridge_chk.sv
module attr_bridge_chk #(
   parameter int ADDR_W   = 12,
   parameter int LANES    = 2,
   parameter int VAL_W    = 8,
   parameter int CTRL_OFS = 'h16C
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic                        wbit0,
   input logic [LANES-1:0]            stb_rd,
   input logic [LANES-1:0][VAL_W-1:0] lane_rdval,
   input logic                        mismatch
);

   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stb_rd[0] |=> !stb_rd[0]);

   assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stb_rd[0] |-> $past(bus_wr && bus_addr == ADDR_W'(CTRL_OFS) && wbit0));

   assert_rdval_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_rd[0] |=> $stable(lane_rdval[0]));

   assert_mismatch_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |=> mismatch);

   assert_mismatch_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mismatch) |-> $past(lane_rdval[0] != lane_rdval[1]));

endmodule

bind attr_bridge attr_bridge_chk #(
   .ADDR_W(ADDR_W), .LANES(LANES), .VAL_W(VAL_W), .CTRL_OFS(CTRL_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .wbit0(bus_wdata[0]), .stb_rd(stb_rd), .lane_rdval(lane_rdval),
   .mismatch(lane_mismatch)
);

// File: tb/test_attr_bridge.sv
module test_attr_bridge;
   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] A_CTRL = 12'h16C, A_ID = 12'h170, A_VAL = 12'h174,
                           A_RD0 = 12'h178, A_RD1 = 12'h17C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        lane_mismatch;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   attr_bridge i_attr_bridge (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lane_mismatch(lane_mismatch)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bw(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic br(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic attr_wr(input logic [31:0] id, input logic [31:0] val,
                          input logic [7:0] wbits, input logic [7:0] ubits);
      bw(A_ID, id); bw(A_VAL, val);
      bw(A_CTRL, 32'(wbits)); bw(A_CTRL, 0);
      if (ubits != 0) begin bw(A_CTRL, 32'(ubits)); bw(A_CTRL, 0); end
   endtask

   task automatic attr_rd(input logic [31:0] id, output logic [31:0] v0, output logic [31:0] v1);
      bw(A_ID, id); bw(A_CTRL, 32'h11); bw(A_CTRL, 0);
      repeat (2) @(negedge clk);
      br(A_RD0, v0); br(A_RD1, v1);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      br(A_CTRL, d); check("R1 ctrl", d, 0);
      br(A_ID, d);   check("R1 id", d, 0);
      br(A_VAL, d);  check("R1 wval", d, 0);
      br(A_RD0, d);  check("R1 rd0", d, 0);
      br(A_RD1, d);  check("R1 rd1", d, 0);
      check("R1 mismatch", 32'(lane_mismatch), 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      bw(A_ID, 32'hDEAD_0023);  br(A_ID, d);  check("R2 id readback", d, 32'hDEAD_0023);
      bw(A_VAL, 32'h1234_565A); br(A_VAL, d); check("R2 wval readback", d, 32'h1234_565A);
      bw(A_CTRL, 32'h0000_0100); br(A_CTRL, d); check("R2 ctrl readback", d, 32'h100);
      bw(A_CTRL, 0);
      br(12'h180, d); check("R2 unmapped", d, 0);
   endtask

   task automatic t_pending();
      logic [31:0] a, b;
      attr_wr(32'h23, 32'h11, 8'h22, 8'h00);
      attr_rd(32'h23, a, b);
      check("R6 lane0 before update", a, 0); check("R6 lane1 before update", b, 0);
      bw(A_CTRL, 32'h44); bw(A_CTRL, 0);
      attr_rd(32'h23, a, b);
      check("R5 lane0 after tx update", a, 32'h11); check("R5 lane1 after tx update", b, 32'h11);
   endtask

   task automatic t_class();
      logic [31:0] a, b;
      attr_wr(32'hA3, 32'h33, 8'h22, 8'h44);
      attr_rd(32'hA3, a, b);
      check("R7 rx attr ignores tx update", a, 0);
      attr_wr(32'hA3, 32'h33, 8'h00, 8'h88);
      attr_rd(32'hA3, a, b);
      check("R7 rx update lane0", a, 32'h33); check("R7 rx update lane1", b, 32'h33);
      attr_wr(32'h26, 32'h01, 8'h22, 8'h00);
      attr_wr(32'h27, 32'h02, 8'h22, 8'h44);
      attr_rd(32'h26, a, b);
      check("R7 whole tx class promoted", a, 32'h01);
   endtask

   task automatic t_level();
      logic [31:0] a, b;
      bw(A_ID, 32'h24); bw(A_VAL, 32'h44); bw(A_CTRL, 32'h22);
      bw(A_VAL, 32'h55); bw(A_CTRL, 32'h22); bw(A_CTRL, 0);
      bw(A_CTRL, 32'h44); bw(A_CTRL, 0);
      attr_rd(32'h24, a, b);
      check("R4 held bit gives no second write", a, 32'h44);
   endtask

   task automatic t_unsupported();
      logic [31:0] a, b;
      attr_wr(32'h40, 32'h77, 8'h22, 8'h44);
      attr_rd(32'h40, a, b);
      check("R8 unsupported id reads zero", a, 0);
      attr_wr(32'h123, 32'h78, 8'h22, 8'h44);
      attr_rd(32'h123, a, b);
      check("R8 wide id reads zero", b, 0);
      attr_rd(32'h23, a, b);
      check("R8 no alias onto 0x23", a, 32'h11);
   endtask

   task automatic t_same_cycle();
      logic [31:0] a, b;
      attr_wr(32'hA5, 32'h5C, 8'hAA, 8'h00);
      attr_rd(32'hA5, a, b);
      check("R9 write+update lane0", a, 32'h5C); check("R9 write+update lane1", b, 32'h5C);
   endtask

   task automatic t_extra_id();
      logic [31:0] a, b;
      attr_wr(32'h89, 32'h9A, 8'h22, 8'h88);
      attr_rd(32'h89, a, b);
      check("R11 0x89 ignores rx update", a, 0);
      bw(A_CTRL, 32'h44); bw(A_CTRL, 0);
      attr_rd(32'h89, a, b);
      check("R11 0x89 tx update", a, 32'h9A);
   endtask

   task automatic t_mismatch();
      logic [31:0] a, b;
      check("R10 no mismatch yet", 32'(lane_mismatch), 0);
      attr_wr(32'h25, 32'h12, 8'h06, 8'h00);
      attr_rd(32'h25, a, b);
      check("R3 lane0 only written", a, 32'h12); check("R3 lane1 untouched", b, 0);
      check("R10 mismatch raised", 32'(lane_mismatch), 1);
      attr_rd(32'h23, a, b);
      check("R10 mismatch sticky", 32'(lane_mismatch), 1);
      do_reset();
      check("R10 cleared by reset", 32'(lane_mismatch), 0);
   endtask

   initial begin
      do_reset();
      t_reset();
      t_regs();
      t_pending();
      t_class();
      t_level();
      t_unsupported();
      t_same_cycle();
      t_extra_id();
      t_mismatch();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule